// File: doc/BRIEF.md
# JTAG Pin-Hold Sequencer

This block is an on-chip JTAG master. It drives TCK, TMS and TDI into the device's internal test access port and samples TDO from it. Its job is to freeze the device pins before the device reconfigures itself. A host pulses `start_req`. The block then loads the sample instruction so that the boundary-scan cells capture the present pin states. Next it walks once through the data-register capture and update states so that the captured values reach the update latches. Finally it loads the clamp instruction, which holds every pin at those values. When the last TCK cycle ends, `held` goes high. The host waits for this before it triggers reconfiguration.

After the device comes back up, the host pulses `release_req` to free the pins. The `release_mode` input selects how this is done. With `release_mode` low, the block forces a TAP reset by keeping TMS high. With `release_mode` high, it loads the all-ones bypass instruction. The block ignores any request that arrives while `busy` is high. TCK runs only during a sequence, and its rate is the system clock divided by 2·`TCK_HALF`.

Top module: `jtag_hold_seq`

## Requirements
- R1: While `rst` is high and after it falls, `tck`, `tms`, `tdi`, `busy` and `held` are 0 and `ir_echo` is all zeros.
- R2: While `busy` is high, `tck` has a period of 2·`TCK_HALF` system clocks. While idle it stays low. `tms` and `tdi` change only on the clock edge where `tck` falls, or on the edge that accepts a request.
- R3: The hold script is exactly 38 TCK cycles. It starts with one cycle of TMS=0, TDI=0. Then comes an instruction load of the sample code. Then comes a data-register pass with TMS 1,0,1,1,0 and TDI=0. It ends with an instruction load of the clamp code. An instruction load is TMS 1,1,0,0, then the 10 code bits on TDI with bit 0 first and TMS=1 only on bit 9, then TMS 1,0. TDI is 0 on every cycle of a load that is not a code bit.
- R4: The instruction codes are 10 bits wide: sample = 00_0000_0101, clamp = 00_0000_1010, bypass = 11_1111_1111.
- R5: `busy` is 1 on the cycle after an accepted request, and it falls on the edge that ends the last TCK cycle. After a hold script, `held` becomes 1 on that same edge.
- R6: With `release_mode`=0 when the request is accepted, the release script is 6 TCK cycles with TMS=1, TDI=1, followed by one cycle with TMS=0, TDI=1. Later changes to `release_mode` have no effect on that run.
- R7: With `release_mode`=1 when the request is accepted, the release script is a single instruction load of the bypass code.
- R8: `held` becomes 0 on the edge that ends either release script. `held` changes on no other edge except the end of a hold script.
- R9: A `start_req` or `release_req` seen while `busy` is high is ignored. The running script continues unchanged.
- R10: `ir_echo[k]` holds the TDO value sampled at the rising TCK of code bit k of the most recent instruction load.
- R11: If `start_req` and `release_req` arrive together while idle, the hold script runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start the pin-hold script |
| release_req | input | 1 | Start the release script |
| release_mode | input | 1 | 0: release by TAP reset, 1: release by bypass load |
| tck | output | 1 | Test clock to the internal TAP |
| tms | output | 1 | Test mode select to the internal TAP |
| tdi | output | 1 | Test data to the internal TAP |
| tdo | input | 1 | Test data from the internal TAP |
| busy | output | 1 | A script is running |
| held | output | 1 | Pins are clamped (hold script completed) |
| ir_echo | output | 10 | TDO bits seen during the latest instruction shift |

## Verification
An accepted request shows as `busy`=1 with the first script bit on `tms`/`tdi` one system clock later. The first TCK rise follows `TCK_HALF` clocks after that. Each further TCK cycle takes 2·`TCK_HALF` clocks. `held`, `busy` and `ir_echo` settle on the edge of the final TCK fall. The bench drives inputs and samples outputs on falling system-clock edges. It compares each TCK rise against the next expected (TMS, TDI) pair in a queue, measures the spacing between rises, and records the TDO it presents so that it can predict `ir_echo`. It checks the status outputs only after `busy` is seen low.

// File: rtl/jhs_pkg.sv
package jhs_pkg;
  localparam int IR_W  = 10;
  localparam int IRB_W = $clog2(IR_W);

  // R4 instruction codes, shifted bit 0 first
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'b00_0000_0101;
  localparam logic [IR_W-1:0] OP_CLAMP  = 10'b00_0000_1010;
  localparam logic [IR_W-1:0] OP_BYPASS = '1;

  localparam int RST_TCKS = 6;
  localparam int IRLD_LEN = IR_W + 6;
  localparam int DRP_LEN  = 5;
  localparam logic [DRP_LEN-1:0] DRP_TMS = 5'b01101;

  localparam int HOLD_LEN = 1 + IRLD_LEN + DRP_LEN + IRLD_LEN;
  localparam int RREL_LEN = RST_TCKS + 1;
  localparam int BREL_LEN = IRLD_LEN;
  localparam int MAX_A    = (HOLD_LEN > RREL_LEN) ? HOLD_LEN : RREL_LEN;
  localparam int MAX_LEN  = (MAX_A > BREL_LEN) ? MAX_A : BREL_LEN;
  localparam int IDX_W    = $clog2(MAX_LEN);

  typedef enum logic [1:0] {SCR_HOLD, SCR_REL_RST, SCR_REL_BYP} script_e;

  typedef struct packed {
    logic             tms;
    logic             tdi;
    logic             ir_shift;
    logic [IRB_W-1:0] ir_bit;
  } step_t;

  function automatic logic [IDX_W-1:0] last_step(script_e s);
    case (s)
      SCR_HOLD:    return IDX_W'(HOLD_LEN - 1);
      SCR_REL_RST: return IDX_W'(RREL_LEN - 1);
      default:     return IDX_W'(BREL_LEN - 1);
    endcase
  endfunction
endpackage

// File: rtl/jhs_tck_gen.sv
module jhs_tck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tck,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          edge_now;

  assign edge_now = run && (cnt == CW'(HALF - 1));
  assign rise     = edge_now && !tck;
  assign fall     = edge_now && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jhs_script.sv
module jhs_script
  import jhs_pkg::*;
(
  input  script_e          sel,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  function automatic step_t ir_load_step(logic [IR_W-1:0] op, int off);
    step_t s;
    logic [IRB_W-1:0] b;
    s = '0;
    b = '0;
    if (off < 2) begin
      s.tms = 1'b1;
    end else if (off < 4) begin
      s.tms = 1'b0;
    end else if (off < 4 + IR_W) begin
      b          = IRB_W'(off - 4);
      s.ir_shift = 1'b1;
      s.ir_bit   = b;
      s.tdi      = op[b];
      s.tms      = (off == 3 + IR_W);
    end else begin
      s.tms = (off == 4 + IR_W);
    end
    return s;
  endfunction

  function automatic step_t step_of(script_e s, logic [IDX_W-1:0] ix);
    step_t r;
    int    i;
    r = '0;
    i = int'(ix);
    case (s)
      SCR_HOLD: begin
        if (i == 0)
          r = '0;
        else if (i < 1 + IRLD_LEN)
          r = ir_load_step(OP_SAMPLE, i - 1);
        else if (i < 1 + IRLD_LEN + DRP_LEN)
          r.tms = DRP_TMS[3'(i - 1 - IRLD_LEN)];
        else
          r = ir_load_step(OP_CLAMP, i - 1 - IRLD_LEN - DRP_LEN);
      end
      SCR_REL_RST: begin
        r.tdi = 1'b1;
        r.tms = (i < RST_TCKS);
      end
      default: r = ir_load_step(OP_BYPASS, i);
    endcase
    return r;
  endfunction

  always_comb step = step_of(sel, idx);
endmodule

// File: rtl/jtag_hold_seq.sv
module jtag_hold_seq
  import jhs_pkg::*;
#(
  parameter int TCK_HALF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic            release_req,
  input  logic            release_mode,
  output logic            tck,
  output logic            tms,
  output logic            tdi,
  input  logic            tdo,
  output logic            busy,
  output logic            held,
  output logic [IR_W-1:0] ir_echo
);
  script_e          sel_q, nsel;
  logic [IDX_W-1:0] idx_q, nidx;
  logic             load, rise, fall, cur_last;
  step_t            stp;
  logic             busy_q, held_q, tms_q, tdi_q;
  logic [IR_W-1:0]  echo_q;

  jhs_tck_gen #(.HALF(TCK_HALF)) u_tck (
    .clk (clk),
    .rst (rst),
    .run (busy_q),
    .tck (tck),
    .rise(rise),
    .fall(fall)
  );

  jhs_script u_scr (
    .sel (nsel),
    .idx (nidx),
    .step(stp)
  );

  assign cur_last = (idx_q == last_step(sel_q));

  always_comb begin
    load = 1'b0;
    nsel = sel_q;
    nidx = idx_q;
    if (!busy_q) begin
      if (start_req) begin
        load = 1'b1;
        nsel = SCR_HOLD;
        nidx = '0;
      end else if (release_req) begin
        load = 1'b1;
        nsel = release_mode ? SCR_REL_BYP : SCR_REL_RST;
        nidx = '0;
      end
    end else if (fall && !cur_last) begin
      load = 1'b1;
      nidx = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SCR_HOLD;
      idx_q  <= '0;
      busy_q <= 1'b0;
      held_q <= 1'b0;
      tms_q  <= 1'b0;
      tdi_q  <= 1'b0;
      echo_q <= '0;
    end else begin
      if (load) begin
        sel_q  <= nsel;
        idx_q  <= nidx;
        busy_q <= 1'b1;
        tms_q  <= stp.tms;
        tdi_q  <= stp.tdi;
      end else if (busy_q && fall && cur_last) begin
        busy_q <= 1'b0;
        tms_q  <= 1'b0;
        tdi_q  <= 1'b0;
        held_q <= (sel_q == SCR_HOLD);
      end
      if (busy_q && rise && stp.ir_shift)
        echo_q[stp.ir_bit] <= tdo;
    end
  end

  assign tms     = tms_q;
  assign tdi     = tdi_q;
  assign busy    = busy_q;
  assign held    = held_q;
  assign ir_echo = echo_q;
endmodule

// File: rtl/jhs_chk.sv
module jhs_chk (
  input logic clk,
  input logic rst,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic held
);
  // R2
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck);

  // R2
  pins_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !($past(tck) && !tck)) |-> ($stable(tms) && $stable(tdi)));

  // R8
  held_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(held) |-> $fell(busy));

  // R1
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tms && !tdi));
endmodule

bind jtag_hold_seq jhs_chk u_chk (
  .clk (clk),
  .rst (rst),
  .tck (tck),
  .tms (tms),
  .tdi (tdi),
  .busy(busy),
  .held(held)
);

// File: tb/jtag_hold_seq_bench.sv
module jtag_hold_seq_bench;
  localparam int HALF = 2;
  localparam int IRW  = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic start_req = 1'b0, release_req = 1'b0, release_mode = 1'b0, tdo = 1'b0;
  logic tck, tms, tdi, busy, held;
  logic [IRW-1:0] ir_echo;

  always #4 clk = ~clk;

  jtag_hold_seq #(.TCK_HALF(HALF)) u_jtag_hold_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .release_req(release_req),
    .release_mode(release_mode), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .busy(busy), .held(held), .ir_echo(ir_echo)
  );

  typedef struct { logic tms; logic tdi; int irb; string req; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic [IRW-1:0] exp_echo = '0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic m, logic d, int irb, string req);
    exp_t e;
    e.tms = m; e.tdi = d; e.irb = irb; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_ir(logic [IRW-1:0] op, string req);
    push(1, 0, -1, req); push(1, 0, -1, req);
    push(0, 0, -1, req); push(0, 0, -1, req);
    for (int k = 0; k < IRW; k++) push(k == IRW - 1, op[k], k, req);
    push(1, 0, -1, req); push(0, 0, -1, req);
  endtask

  task automatic push_hold();
    push(0, 0, -1, "R3");
    push_ir(10'b00_0000_0101, "R3");  // R4 sample code
    push(1, 0, -1, "R3"); push(0, 0, -1, "R3"); push(1, 0, -1, "R3");
    push(1, 0, -1, "R3"); push(0, 0, -1, "R3");
    push_ir(10'b00_0000_1010, "R3");  // R4 clamp code
  endtask

  task automatic push_rel_rst();
    for (int k = 0; k < 6; k++) push(1, 1, -1, "R6");
    push(0, 1, -1, "R6");
  endtask

  task automatic push_rel_byp();
    push_ir(10'b11_1111_1111, "R7");  // R4 bypass code
  endtask

  task automatic pulse(bit s, bit r);
    start_req = s; release_req = r;
    @(negedge clk);
    start_req = 1'b0; release_req = 1'b0;
  endtask

  task automatic wait_idle(string req);
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check(!busy, req, "sequence end", busy, 0);
    check(q.size() == 0, req, "leftover steps", q.size(), 0);
    check(!tck, "R2", "tck idle", tck, 0);
  endtask

  // scoreboard monitor: compares every TCK rise with the queue head
  initial begin : mon
    logic prev;
    int cyc, last_rise;
    exp_t e;
    prev = 1'b0; cyc = 0; last_rise = -1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        prev = 1'b0;
      end else begin
        if (tck && !prev) begin
          if (last_rise >= 0)
            check(cyc - last_rise == 2 * HALF, "R2", "tck period", cyc - last_rise, 2 * HALF);
          last_rise = cyc;
          if (q.size() == 0) begin
            check(0, "R9", "unexpected tck rise", 1, 0);
          end else begin
            e = q.pop_front();
            check(tms == e.tms, e.req, "tms", tms, e.tms);
            check(tdi == e.tdi, e.req, "tdi", tdi, e.tdi);
            if (e.irb >= 0) exp_echo[e.irb] = tdo;
          end
        end
        if (!tck && prev) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          tdo  = lfsr[0];
        end
        if (!busy) last_rise = -1;
        prev = tck;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check({tck, tms, tdi, busy, held} == 5'b0, "R1", "outputs in reset", {tck, tms, tdi, busy, held}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({tck, tms, tdi, busy, held} == 5'b0, "R1", "outputs after reset", {tck, tms, tdi, busy, held}, 0);
    check(ir_echo == '0, "R1", "ir_echo after reset", ir_echo, 0);

    // hold script, with stray requests in the middle
    push_hold();
    pulse(1, 0);
    check(busy, "R5", "busy after start", busy, 1);
    repeat (40) @(negedge clk);
    pulse(1, 1);
    check(busy, "R9", "busy kept on stray request", busy, 1);
    wait_idle("R3");
    check(held, "R5", "held after hold", held, 1);
    check(ir_echo == exp_echo, "R10", "echo after hold", ir_echo, exp_echo);

    // release by TAP reset; mode flips after acceptance
    release_mode = 1'b0;
    push_rel_rst();
    pulse(0, 1);
    release_mode = 1'b1;
    check(busy && held, "R8", "held during release", {busy, held}, 2'b11);
    wait_idle("R6");
    check(!held, "R8", "held after reset release", held, 0);
    check(ir_echo == exp_echo, "R10", "echo unchanged by reset release", ir_echo, exp_echo);

    // hold again, then release by bypass
    push_hold();
    pulse(1, 0);
    wait_idle("R3");
    check(held, "R5", "held after second hold", held, 1);
    release_mode = 1'b1;
    push_rel_byp();
    pulse(0, 1);
    wait_idle("R7");
    check(!held, "R8", "held after bypass release", held, 0);
    check(ir_echo == exp_echo, "R10", "echo after bypass load", ir_echo, exp_echo);

    // simultaneous requests while idle
    release_mode = 1'b0;
    push_hold();
    pulse(1, 1);
    wait_idle("R11");
    check(held, "R11", "held after simultaneous requests", held, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule